// File: doc/BRIEF.md
# Configuration Image Loader Sequencer

This block takes a configuration image arriving as a valid/ready byte stream and programs a programmable target through a byte-wide configuration port. A start pulse latches the total image size. If the size is too small to hold a header, the block reports an error at once. Otherwise it consumes a 16-byte header and decodes the payload length from its first four bytes. It then checks that this length fits within the image. An image that fails either check is rejected, and the target is never reset or written.

An accepted image runs a fixed sequence. The target reset is pulsed and the block waits a settle time. One zero byte is sent, followed by a second settle time. The payload is then streamed straight from the input to the port. Five zero bytes of padding follow the payload. The block then samples the target's error line. If the line is high, the block reports failure and leaves the interrupt enable low. If it is low, the block waits a third settle time, then raises done and the interrupt enable. The settle time is a parameter in clock cycles. Any image bytes beyond the header and payload are left unconsumed in the stream.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset, busy, done, error, irq_en, tgt_reset, cfg_strobe and s_ready are all low.
- R2: A start pulse while busy is ignored and leaves the running sequence unchanged. An accepted start (while not busy) clears done, error and irq_en in the next cycle.
- R3: The first 16 accepted stream bytes form the header. Header bytes 0 to 3 hold the payload length, most significant byte first. Bytes 4 to 15 are consumed and otherwise ignored.
- R4: If img_size is below 16, error is high and busy low one cycle after start, and no stream byte is consumed. If the declared length exceeds img_size minus 16, error is set after the 16th header byte. In both cases tgt_reset and cfg_strobe never rise.
- R5: After the header, tgt_reset is high for exactly one cycle. cfg_strobe first rises SETTLE_CYC+1 cycles after that cycle, carrying a single 0x00 byte.
- R6: After the preamble byte is accepted, nothing is transferred for SETTLE_CYC cycles. Then exactly the declared number of payload bytes, taken from image offsets 16 onward, appear on cfg_data in order, one per cfg_strobe/cfg_ready handshake.
- R7: Directly after the payload, exactly five 0x00 bytes are transferred. With a zero length they follow the preamble wait directly.
- R8: If tgt_err is high in the cycle after the last padding byte is accepted, error rises in the next cycle, and done and irq_en stay low.
- R9: If tgt_err is low at that point, done and irq_en rise SETTLE_CYC+2 cycles after the cycle in which the last padding byte is accepted.
- R10: s_ready is low during every settle wait. During the payload, s_ready is low whenever cfg_ready is low.
- R11: busy is high from an accepted start until done or error is raised, and is never high together with done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| img_size | input | 32 | Total image size in bytes, latched at start |
| s_valid | input | 1 | Image byte valid |
| s_data | input | 8 | Image byte |
| s_ready | output | 1 | Image byte accepted when high with s_valid |
| tgt_err | input | 1 | Error line from the target |
| cfg_ready | input | 1 | Target port can take a byte |
| tgt_reset | output | 1 | Target reset pulse |
| cfg_data | output | 8 | Byte to the target port |
| cfg_strobe | output | 1 | cfg_data is valid |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Load finished without error |
| error | output | 1 | Image rejected or target reported failure |
| irq_en | output | 1 | Interrupt enable, raised only on success |

## Verification
Images are tried with sizes below the header, with an exact-fit length, with a zero length, and with lengths one to five bytes past the limit. These cases separate the two rejection paths from the full sequence and test the boundary of the length comparison. Random stream stalls and port stalls show whether flow control ever drops, repeats or reorders a byte. The byte log and the cycle stamps of the reset, preamble and last pad byte pin the settle waits to their exact lengths. Runs with the target error line raised, and a start pulsed mid-run, separate the failure path and the start-ignore rule from normal completion.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
  localparam int LEN_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_TRST, ST_SETTLE_A, ST_LEAD,
    ST_SETTLE_B, ST_BODY, ST_TAIL, ST_CHECK, ST_SETTLE_C
  } ld_state_e;

  // declared payload must fit behind the header
  function automatic logic len_fits(input logic [LEN_W-1:0] size,
                                    input logic [LEN_W-1:0] len,
                                    input logic [LEN_W-1:0] hdr);
    return (size >= hdr) && (len <= size - hdr);
  endfunction

  // big-endian accumulate of one byte
  function automatic logic [LEN_W-1:0] be_push(input logic [LEN_W-1:0] acc,
                                               input logic [7:0] b);
    return {acc[LEN_W-9:0], b};
  endfunction
endpackage

// File: rtl/cfgload_hdr.sv
module cfgload_hdr
  import cfgload_pkg::*;
#(
  parameter int HDR_BYTES = 16,
  parameter int LEN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       byte_in,
  output logic [LEN_W-1:0] len,
  output logic             last
);
  localparam int IW = $clog2(HDR_BYTES);

  logic [IW-1:0] idx;
  logic          in_len_field;

  assign in_len_field = (idx < IW'(LEN_BYTES));
  assign last         = (idx == IW'(HDR_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      len <= '0;
    end else if (clr) begin
      idx <= '0;
      len <= '0;
    end else if (take) begin
      if (in_len_field) len <= be_push(len, byte_in);
      idx <= idx + 1'b1;
    end
  end

  // bytes past the length field never alter the decoded length
  p_len_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_len_field) |=> (clr || $stable(len)));
endmodule

// File: rtl/cfgload_timer.sv
module cfgload_timer #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int TW = $clog2(SETTLE_CYC + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= TW'(SETTLE_CYC - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cfgload_bytecnt.sv
module cfgload_bytecnt
  import cfgload_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] val,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == LEN_W'(1));
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfgload_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int HDR_BYTES  = 16,
  parameter int PAD_BYTES  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_size,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  input  logic             tgt_err,
  input  logic             cfg_ready,
  output logic             tgt_reset,
  output logic [7:0]       cfg_data,
  output logic             cfg_strobe,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             irq_en
);
  localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] PAD_LEN = LEN_W'(PAD_BYTES);

  ld_state_e        state, state_nx;
  logic [LEN_W-1:0] size_q, hdr_len, cnt_val;
  logic             done_q, err_q, irq_q;
  logic             hdr_last, tmr_exp, cnt_last;

  // named events
  logic start_acc, early_reject, reject_ev, hs_in, hs_out;
  logic tmr_load, cnt_load, cnt_dec, in_settle, tgt_fail_ev, success_ev;

  assign hs_in        = s_valid && s_ready;
  assign hs_out       = cfg_strobe && cfg_ready;
  assign start_acc    = start && (state == ST_IDLE);
  assign early_reject = start_acc && (img_size < HDR_LEN);
  assign reject_ev    = (state == ST_HDR) && hs_in && hdr_last &&
                        !len_fits(size_q, hdr_len, HDR_LEN);
  assign in_settle    = (state == ST_SETTLE_A) || (state == ST_SETTLE_B) ||
                        (state == ST_SETTLE_C);
  assign tgt_fail_ev  = (state == ST_CHECK) && tgt_err;
  assign success_ev   = (state == ST_SETTLE_C) && tmr_exp;
  assign tmr_load     = (state == ST_TRST) || ((state == ST_LEAD) && hs_out) ||
                        ((state == ST_CHECK) && !tgt_err);
  assign cnt_load     = ((state == ST_SETTLE_B) && tmr_exp) ||
                        ((state == ST_BODY) && hs_out && cnt_last);
  assign cnt_val      = ((state == ST_SETTLE_B) && hdr_len != '0) ? hdr_len : PAD_LEN;
  assign cnt_dec      = hs_out && ((state == ST_BODY) || (state == ST_TAIL));

  cfgload_hdr #(.HDR_BYTES(HDR_BYTES), .LEN_BYTES(LEN_W / 8)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr(start_acc),
    .take((state == ST_HDR) && hs_in), .byte_in(s_data),
    .len(hdr_len), .last(hdr_last)
  );

  cfgload_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(tmr_exp)
  );

  cfgload_bytecnt u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .val(cnt_val),
    .dec(cnt_dec), .last(cnt_last)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (start_acc && !early_reject) state_nx = ST_HDR;
      ST_HDR:      if (hs_in && hdr_last) state_nx = reject_ev ? ST_IDLE : ST_TRST;
      ST_TRST:     state_nx = ST_SETTLE_A;
      ST_SETTLE_A: if (tmr_exp) state_nx = ST_LEAD;
      ST_LEAD:     if (hs_out) state_nx = ST_SETTLE_B;
      ST_SETTLE_B: if (tmr_exp) state_nx = (hdr_len != '0) ? ST_BODY : ST_TAIL;
      ST_BODY:     if (hs_out && cnt_last) state_nx = ST_TAIL;
      ST_TAIL:     if (hs_out && cnt_last) state_nx = ST_CHECK;
      ST_CHECK:    state_nx = tgt_err ? ST_IDLE : ST_SETTLE_C;
      ST_SETTLE_C: if (tmr_exp) state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      size_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_acc) begin
        size_q <= img_size;
        done_q <= 1'b0;
        irq_q  <= 1'b0;
        err_q  <= early_reject;
      end else if (reject_ev || tgt_fail_ev) begin
        err_q  <= 1'b1;
      end else if (success_ev) begin
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign error      = err_q;
  assign irq_en     = irq_q;
  assign tgt_reset  = (state == ST_TRST);
  assign s_ready    = (state == ST_HDR) || ((state == ST_BODY) && cfg_ready);
  assign cfg_strobe = (state == ST_LEAD) || (state == ST_TAIL) ||
                      ((state == ST_BODY) && s_valid);
  assign cfg_data   = (state == ST_BODY) ? s_data : 8'h00;

  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset |=> (!tgt_reset && !cfg_strobe));
  p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (!busy && error && !tgt_reset && !cfg_strobe));
  p_settle_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_settle |-> (!s_ready && !cfg_strobe));
  p_body_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BODY) && !cfg_ready) |-> !s_ready);
  p_busy_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !error));
  p_irq_success_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |-> (done && !error));
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !tgt_fail_ev && !success_ev && !reject_ev) |=> busy);
endmodule

// File: tb/cfg_image_loader_bench.sv
`timescale 1ns/1ps
module cfg_image_loader_bench;
  localparam int S = 6;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] img_size = '0;
  logic        s_valid = 1'b0, tgt_err = 1'b0, cfg_ready = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready, tgt_reset, cfg_strobe, busy, done, error, irq_en;
  logic [7:0]  cfg_data;

  cfg_image_loader #(.SETTLE_CYC(S)) u_cfg_image_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .img_size(img_size),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .tgt_err(tgt_err),
    .cfg_ready(cfg_ready), .tgt_reset(tgt_reset), .cfg_data(cfg_data),
    .cfg_strobe(cfg_strobe), .busy(busy), .done(done), .error(error),
    .irq_en(irq_en)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] img [0:63];
  int cur_size = 0;
  bit arm_clr = 1'b0;

  // monitor state, written only by the monitor loop
  logic [7:0] log_b [0:127];
  int log_n = 0, ptr = 0, cyc = 0, rst_cnt = 0, rst_cyc = 0;
  int first_stb = -1, pre_acc = -1, act_after = -1, last_acc = -1;
  int end_cyc = -1, stall_viol = 0, flag_viol = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_fits(input int size, input int len);
    return (size >= 16) && (len <= size - 16);
  endfunction

  function automatic int exp_byte(input int i, input int len);
    if (i >= 1 && i <= len) return int'(img[16 + i - 1]);
    return 0;
  endfunction

  // drive at negedge, settle, then sample the state seen by the next edge
  always begin
    @(negedge clk);
    s_valid   = (ptr < cur_size) && (($urandom % 4) != 0);
    s_data    = (ptr < cur_size && ptr < 64) ? img[ptr] : 8'h00;
    cfg_ready = (($urandom % 4) != 0);
    #3;
    cyc++;
    if (tgt_reset) begin rst_cnt++; rst_cyc = cyc; end
    if (cfg_strobe && first_stb < 0 && rst_cnt > 0) first_stb = cyc;
    if (pre_acc >= 0 && act_after < 0 && (s_ready || cfg_strobe)) act_after = cyc;
    if (s_ready && !cfg_ready && log_n >= 1) stall_viol++;
    if (cfg_strobe && cfg_ready) begin
      if (log_n < 128) log_b[log_n] = cfg_data;
      if (log_n == 0) pre_acc = cyc;
      log_n++;
      last_acc = cyc;
    end
    if (s_valid && s_ready) ptr++;
    if ((done || error) && end_cyc < 0) end_cyc = cyc;
    if (busy && (done || error)) flag_viol++;
    if (start && arm_clr) begin
      log_n = 0; ptr = 0; rst_cnt = 0; first_stb = -1; pre_acc = -1;
      act_after = -1; last_acc = -1; end_cyc = -1; stall_viol = 0; flag_viol = 0;
    end
  end

  task automatic run_case(input int size, input int len, input bit terr, input bit poke);
    int guard = 0;
    int bad_pay = 0, bad_pad = 0;
    bit ok_img = exp_fits(size, len);
    for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
    img[0] = 8'(len >> 24); img[1] = 8'(len >> 16);
    img[2] = 8'(len >> 8);  img[3] = 8'(len);
    tgt_err  = terr;
    img_size = 32'(size);
    @(negedge clk);
    cur_size = size;
    arm_clr = 1'b1; start = 1'b1;
    @(negedge clk);
    arm_clr = 1'b0; start = 1'b0;
    #4;
    // R2: accepted start clears previous flags
    chk(!done && !irq_en, "R2 start clears done", done, 0);
    if (size < 16) begin
      chk(error && !busy, "R4 short image error", error, 1);
      chk(ptr == 0, "R4 short image consumes nothing", ptr, 0);
    end else begin
      chk(busy && !error, "R11 busy after start", busy, 1);
    end
    while (!(done || error) && guard < 5000) begin
      @(negedge clk);
      start = (poke && guard == 25);
      #4;
      guard++;
    end
    start = 1'b0;
    if (guard >= 5000) chk(1'b0, "R11 run did not finish", guard, 5000);
    chk(!busy && flag_viol == 0, "R11 busy excludes flags", flag_viol, 0);
    if (!ok_img) begin
      chk(error && !done && !irq_en, "R4 reject flags", error, 1);
      chk(rst_cnt == 0 && log_n == 0, "R4 target untouched", rst_cnt + log_n, 0);
      if (size >= 16) chk(ptr == 16, "R3 header consumed", ptr, 16);
    end else begin
      chk(rst_cnt == 1, "R5 one reset cycle", rst_cnt, 1);
      chk(first_stb - rst_cyc == S + 1, "R5 settle before preamble", first_stb - rst_cyc, S + 1);
      chk(log_n == len + 6, "R6 byte count", log_n, len + 6);
      chk(log_b[0] == 8'h00, "R5 preamble value", int'(log_b[0]), 0);
      for (int i = 1; i <= len && i < 128; i++)
        if (int'(log_b[i]) != exp_byte(i, len)) bad_pay++;
      for (int i = len + 1; i <= len + 5 && i < 128; i++)
        if (log_b[i] != 8'h00) bad_pad++;
      chk(bad_pay == 0, "R6 payload order", bad_pay, 0);
      chk(bad_pad == 0, "R7 padding zeros", bad_pad, 0);
      if (len == 0) chk(act_after - pre_acc == S + 1, "R7 pad after wait", act_after - pre_acc, S + 1);
      else chk(act_after - pre_acc >= S + 1, "R6 wait after preamble", act_after - pre_acc, S + 1);
      chk(stall_viol == 0, "R10 ready follows port", stall_viol, 0);
      chk(ptr == 16 + len, "R3 stream consumed", ptr, 16 + len);
      if (terr) begin
        chk(error && !done && !irq_en, "R8 target error", error, 1);
        chk(end_cyc - last_acc == 2, "R8 error timing", end_cyc - last_acc, 2);
      end else begin
        chk(done && irq_en && !error, "R9 done and irq", done, 1);
        chk(end_cyc - last_acc == S + 2, "R9 final settle", end_cyc - last_acc, S + 2);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk(!busy && !done && !error && !irq_en, "R1 reset flags", busy + done + error, 0);
    chk(!tgt_reset && !cfg_strobe && !s_ready, "R1 reset outputs", tgt_reset + cfg_strobe, 0);
    // directed corners
    run_case(0, 0, 1'b0, 1'b0);
    run_case(15, 0, 1'b0, 1'b0);
    run_case(16, 0, 1'b0, 1'b0);
    run_case(16, 1, 1'b0, 1'b0);
    run_case(40, 24, 1'b0, 1'b0);
    run_case(40, 25, 1'b0, 1'b0);
    run_case(30, 8, 1'b1, 1'b0);
    run_case(50, 20, 1'b0, 1'b1);
    run_case(20, 3, 1'b0, 1'b0);
    // constrained random
    for (int k = 0; k < 30; k++) begin
      int size = 16 + int'($urandom % 45);
      int room = size - 16;
      int len  = (($urandom % 10) < 7) ? int'($urandom % (room + 1))
                                       : room + 1 + int'($urandom % 5);
      run_case(size, len, (($urandom % 5) == 0), (($urandom % 4) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule